// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Responder

This block sits on the device side of an SPI link and answers a master that issues the dual-output fast-read command. It behaves like the read path of a serial flash, and its purpose is system-level testing. All logic runs on one system clock. The serial clock, the chip select and the IO0 input are synchronised into that domain, and the serial clock's rising and falling edges are detected there. The master must therefore keep the serial clock well below the system clock. The bench uses one eighth of it per half period.

After chip select falls, the block shifts in an 8-bit opcode on IO0, then a 24-bit address and then eight dummy clocks. After that it drives data bytes from a small preloadable byte store, two bits per serial clock. Opcodes other than the dual-output read are ignored for the rest of the frame. The store is filled through a simple synchronous write port on the system clock.

The sequencer has seven states:
- `ST_IDLE`: chip select inactive.
- `ST_OPCODE`: shifting in 8 bits.
- `ST_ADDR`: shifting in 24 bits.
- `ST_DUMMY`: counting 8 rising edges.
- `ST_TURN`: waiting for the falling edge after the last dummy clock.
- `ST_STREAM`: driving data.
- `ST_IGNORE`: rejected opcode.

The transitions are:
- IDLE→OPCODE when chip select goes active.
- OPCODE→ADDR when the eighth bit completes opcode 0x3B; OPCODE→IGNORE when the eighth bit completes any other value.
- ADDR→DUMMY on the 24th address bit.
- DUMMY→TURN on the 8th dummy rising edge.
- TURN→STREAM on the next falling edge.
- Any state→IDLE when chip select goes inactive.

Top module: `dual_read_responder`

## Requirements
- R1: After reset both output enables (`io0_oe`, `io1_oe`) are low.
- R2: The data phase is entered only when the first 8 bits sampled on IO0 at serial-clock rising edges, MSB first, equal 0x3B.
- R3: The next 24 IO0 bits form the start address, MSB first. Only its low `MEM_AW` bits select the first byte; the upper bits have no effect.
- R4: Eight dummy rising edges follow the address. The IO0 values sampled during them have no effect, and both lines stay undriven (enables low) through the opcode, address and dummy phases.
- R5: Both enables go high together after the serial-clock falling edge that follows the 40th rising edge. They stay high while chip select remains active.
- R6: Each byte takes four serial clocks. In pair k (k = 0..3), IO1 carries bit 7-2k and IO0 carries bit 6-2k. The output bits change only after a serial-clock falling edge.
- R7: Bytes continue from successive addresses for as long as chip select stays active.
- R8: After the last store location (2^MEM_AW − 1) the address wraps to location 0.
- R9: Chip select going inactive at any point drops both enables. The next frame starts decoding from its first opcode bit.
- R10: After an opcode other than 0x3B, both enables stay low for the rest of the frame, whatever the serial clock does.
- R11: When `pre_we` is high at a system clock edge, `pre_data` is written to store location `pre_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select from the master, active low |
| sck | input | 1 | Serial clock from the master, idle low |
| io0_in | input | 1 | IO0 value seen at the pin |
| io0_out | output | 1 | IO0 output value |
| io0_oe | output | 1 | IO0 output enable |
| io1_out | output | 1 | IO1 output value |
| io1_oe | output | 1 | IO1 output enable |
| pre_we | input | 1 | Store preload write strobe |
| pre_addr | input | MEM_AW | Store preload location |
| pre_data | input | 8 | Store preload byte |

## Verification
Most faults in the sequencer or its counters show up within one frame. A bit counter that is off by one either shifts the address, which gives the wrong first byte in the very first data pair, or moves the turnaround, which raises the enables one serial clock early or late. A fault in the pair shifter or the index increment shows up as a swapped bit within four serial clocks, or as a wrong second byte. A missing wrap only appears when a read crosses the top location, so the address sweep covers every start location, including the last one.

// File: rtl/drr_pkg.sv
package drr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DUMMY  = 3'd3,
        ST_TURN   = 3'd4,
        ST_STREAM = 3'd5,
        ST_IGNORE = 3'd6
    } drr_phase_t;

    localparam int BYTE_W   = 8;
    localparam int PAIR_CNT = BYTE_W / 2;

endpackage

// File: rtl/drr_sync.sv
module drr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic io0_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            cs_pipe  <= '1;
            dat_pipe <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sck};
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
            dat_pipe <= {dat_pipe[STAGES-2:0], io0_in};
            sck_last <= sck_pipe[TOP];
        end
    end

    assign sck_rise = sck_pipe[TOP] & ~sck_last;
    assign sck_fall = ~sck_pipe[TOP] & sck_last;
    assign cs_act   = ~cs_pipe[TOP];
    assign mosi     = dat_pipe[TOP];

endmodule

// File: rtl/drr_store.sv
module drr_store #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/drr_seq.sv
module drr_seq
    import drr_pkg::*;
#(
    parameter int          AW         = 6,
    parameter int          ADDR_BITS  = 24,
    parameter int          DUMMY_CLKS = 8,
    parameter logic [7:0]  CMD_CODE   = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [AW-1:0]     rd_idx,
    output drr_phase_t        phase,
    output logic              drv_io0,
    output logic              drv_io1,
    output logic              drv_en
);
    localparam int CNT_MAX = (ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int SH      = (AW > BYTE_W - 1) ? AW : BYTE_W - 1;
    localparam int PW      = $clog2(PAIR_CNT);

    drr_phase_t        state, state_nx;
    logic [CW-1:0]     cnt;
    logic [SH-1:0]     shreg;
    logic [AW-1:0]     idx;
    logic [BYTE_W-1:0] dbuf;
    logic [PW-1:0]     pair;

    // next-state decode
    always_comb begin
        state_nx = state;
        if (!cs_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_OPCODE;
                ST_OPCODE: begin
                    if (sck_rise && cnt == CW'(BYTE_W - 1)) begin
                        state_nx = ({shreg[BYTE_W-2:0], mosi} == CMD_CODE) ? ST_ADDR : ST_IGNORE;
                    end
                end
                ST_ADDR: begin
                    if (sck_rise && cnt == CW'(ADDR_BITS - 1)) state_nx = ST_DUMMY;
                end
                ST_DUMMY: begin
                    if (sck_rise && cnt == CW'(DUMMY_CLKS - 1)) state_nx = ST_TURN;
                end
                ST_TURN: begin
                    if (sck_fall) state_nx = ST_STREAM;
                end
                ST_STREAM: state_nx = ST_STREAM;
                ST_IGNORE: state_nx = ST_IGNORE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            idx     <= '0;
            dbuf    <= '0;
            pair    <= '0;
            drv_io0 <= 1'b0;
            drv_io1 <= 1'b0;
            drv_en  <= 1'b0;
        end else begin
            drv_en <= (state_nx == ST_STREAM);
            if (!cs_act || state == ST_IDLE) begin
                cnt  <= '0;
                pair <= '0;
            end else begin
                unique case (state)
                    ST_OPCODE, ST_ADDR: begin
                        if (sck_rise) begin
                            shreg <= {shreg[SH-2:0], mosi};
                            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
                            if (state == ST_ADDR && state_nx == ST_DUMMY) begin
                                idx <= {shreg[AW-2:0], mosi};
                            end
                        end
                    end
                    ST_DUMMY: begin
                        if (sck_rise) cnt <= cnt + 1'b1;
                    end
                    ST_TURN, ST_STREAM: begin
                        if (sck_fall) begin
                            if (state == ST_TURN || pair == '0) begin
                                {drv_io1, drv_io0} <= rd_byte[BYTE_W-1 -: 2];
                                dbuf               <= {rd_byte[BYTE_W-3:0], 2'b00};
                                idx                <= idx + 1'b1;
                                pair               <= PW'(1);
                            end else begin
                                {drv_io1, drv_io0} <= dbuf[BYTE_W-1 -: 2];
                                dbuf               <= {dbuf[BYTE_W-3:0], 2'b00};
                                pair               <= pair + 1'b1;
                            end
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        cnt <= '0;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    assign rd_idx = idx;
    assign phase  = state;

endmodule

// File: rtl/dual_read_responder.sv
module dual_read_responder
    import drr_pkg::*;
#(
    parameter int         MEM_AW     = 6,
    parameter int         ADDR_BITS  = 24,
    parameter int         DUMMY_CLKS = 8,
    parameter int         SYNC_STG   = 2,
    parameter logic [7:0] CMD_CODE   = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              io0_in,
    output logic              io0_out,
    output logic              io0_oe,
    output logic              io1_out,
    output logic              io1_oe,
    input  logic              pre_we,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [7:0]        pre_data
);
    logic              sck_rise, sck_fall, cs_act, mosi;
    logic [MEM_AW-1:0] rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    drr_phase_t        phase;
    logic              drv_en;

    drr_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .io0_in   (io0_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .mosi     (mosi)
    );

    drr_store #(.AW(MEM_AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (pre_we),
        .waddr (pre_addr),
        .wdata (pre_data),
        .raddr (rd_idx),
        .rdata (rd_byte)
    );

    drr_seq #(
        .AW         (MEM_AW),
        .ADDR_BITS  (ADDR_BITS),
        .DUMMY_CLKS (DUMMY_CLKS),
        .CMD_CODE   (CMD_CODE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi     (mosi),
        .rd_byte  (rd_byte),
        .rd_idx   (rd_idx),
        .phase    (phase),
        .drv_io0  (io0_out),
        .drv_io1  (io1_out),
        .drv_en   (drv_en)
    );

    assign io0_oe = drv_en;
    assign io1_oe = drv_en;

endmodule

// File: rtl/drr_checker.sv
module drr_checker
    import drr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       sck_fall,
    input drr_phase_t phase,
    input logic       io0_oe,
    input logic       io1_oe,
    input logic       io0_out,
    input logic       io1_out
);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!io0_oe && !io1_oe));

    assert_hiz_until_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_STREAM) |-> (!io0_oe && !io1_oe));

    assert_drive_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_STREAM) |-> (io0_oe && io1_oe));

    assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io0_oe && !sck_fall) |=> (!io0_oe || $stable({io1_out, io0_out})));

    assert_ignore_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IGNORE) |=> (phase == ST_IGNORE || phase == ST_IDLE));

endmodule

bind dual_read_responder drr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sck_fall (sck_fall),
    .phase    (phase),
    .io0_oe   (io0_oe),
    .io1_oe   (io1_oe),
    .io0_out  (io0_out),
    .io1_out  (io1_out)
);

// File: tb/tb_dual_read_responder.sv
`timescale 1ns/1ps
module tb_dual_read_responder;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, io0_in = 1'b0;
    logic          io0_out, io0_oe, io1_out, io1_oe;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [7:0]    pre_data = '0;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    dual_read_responder #(.MEM_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io0_in(io0_in),
        .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic preload(input int a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = AW'(a); pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
        model[a] = d;
    endtask

    // one frame: opcode, address, dummies, then npairs serial clocks
    task automatic frame(input logic [7:0] cmd, input logic [23:0] addr, input logic [7:0] dpat,
                         input int npairs, input bit want_data, input string tag);
        logic [39:0] hdr;
        hdr = {cmd, addr, dpat};
        cs_n = 1'b0;
        half_wait();
        for (int i = 0; i < 40; i++) begin
            io0_in = hdr[39-i];
            half_wait();
            if (i >= 32) chk(!io0_oe && !io1_oe, "R4 undriven in dummy", int'(io0_oe | io1_oe), 0);
            sck = 1'b1;
            half_wait();
            sck = 1'b0;
        end
        io0_in = 1'b0;
        for (int p = 0; p < npairs; p++) begin
            int a, k, bt, e1, e0;
            half_wait();
            k  = p % 4;
            a  = (int'(addr[AW-1:0]) + p / 4) % DEPTH;
            bt = int'(model[a]);
            e1 = (bt >> (7 - 2*k)) & 1;
            e0 = (bt >> (6 - 2*k)) & 1;
            if (want_data) begin
                chk(io0_oe && io1_oe, (p == 0) ? "R2 opcode accepted" : "R5 enables held",
                    int'(io0_oe & io1_oe), 1);
                if (tag != "")
                    chk({io1_out, io0_out} == 2'(e1*2 + e0), tag, int'({io1_out, io0_out}), e1*2 + e0);
                else if (p == 0)
                    chk({io1_out, io0_out} == 2'(e1*2 + e0), "R3 first pair", int'({io1_out, io0_out}), e1*2 + e0);
                else if (int'(addr[AW-1:0]) + p / 4 >= DEPTH)
                    chk({io1_out, io0_out} == 2'(e1*2 + e0), "R8 wrapped", int'({io1_out, io0_out}), e1*2 + e0);
                else if (p >= 4)
                    chk({io1_out, io0_out} == 2'(e1*2 + e0), "R7 next byte", int'({io1_out, io0_out}), e1*2 + e0);
                else
                    chk({io1_out, io0_out} == 2'(e1*2 + e0), "R6 pair order", int'({io1_out, io0_out}), e1*2 + e0);
            end else begin
                chk(!io0_oe && !io1_oe, "R10 rejected opcode", int'(io0_oe | io1_oe), 0);
            end
            sck = 1'b1;
            half_wait();
            sck = 1'b0;
        end
        half_wait();
        cs_n = 1'b1;
        half_wait();
        chk(!io0_oe && !io1_oe, "R9 release", int'(io0_oe | io1_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!io0_oe, "R1 io0 enable", int'(io0_oe), 0);
        chk(!io1_oe, "R1 io1 enable", int'(io1_oe), 0);

        for (int i = 0; i < DEPTH; i++) preload(i, 8'((i * 37 + 5) & 255));

        // every start location, upper address bits and dummy bits varied
        for (int k = 0; k < DEPTH; k++) begin
            logic [23:0] ad;
            ad = ((24'(k) * 24'h00A3C1) & 24'hFFFFC0) | 24'(k);
            frame(8'h3B, ad, 8'(k * 29), 8, 1'b1, "");
        end

        // long burst through the top location
        frame(8'h3B, 24'h7F003C, 8'hFF, 4 * 70, 1'b1, "");

        // rejected opcodes
        frame(8'h0B, 24'h000010, 8'h00, 12, 1'b0, "");
        frame(8'h3A, 24'h000011, 8'h55, 12, 1'b0, "");
        frame(8'hBB, 24'h000012, 8'hAA, 12, 1'b0, "");

        // abort mid-byte, then a fresh frame must restart cleanly
        frame(8'h3B, 24'h000014, 8'h00, 6, 1'b1, "");
        frame(8'h3B, 24'h000014, 8'h00, 4, 1'b1, "R9 restart");

        // preload overwrite seen through a read
        preload(7, 8'hA5);
        preload(8, 8'h3C);
        frame(8'h3B, 24'h000007, 8'h00, 8, 1'b1, "R11 preload");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule